// File: doc/BRIEF.md
# External Interrupt Edge Controller

This block turns pin activity on a set of general-purpose ports into interrupt requests and event pulses. It watches sixteen lines. Line n is fed by pin n of one port, and a per-line selection field chooses that port. Each line is resynchronised to the controller clock. A change is then reported as a rising or a falling edge.

Software sets up each line through a small register bus. Each line has a rising-edge enable, a falling-edge enable, an interrupt mask and an event mask. An enabled edge on a line whose interrupt mask is set records a pending flag. Rising and falling edges each have their own pending flag. The line's interrupt request stays high until software clears those flags with write-one-to-clear accesses. An enabled edge on a line whose event mask is set produces a one-cycle pulse and records nothing.

The register bus is a plain write strobe with address and data, plus a combinational read port. There is no stream traffic, so there is no valid/ready handshake and no back-pressure. A write is accepted on every clock edge where the strobe is high.

Top module: `extint_edge_ctrl`

## Requirements
- R1: After reset, every register reads 0, every pending flag is clear, and `irq` and `evt` are all 0.
- R2: Word addresses 0 to 3 hold the port selection fields. Line n uses word n>>2, bits 8*(n&3)+7 down to 8*(n&3). A value p below NUM_PORTS routes bit p*16+n of `port_pins` to line n. Any larger value drives the line constantly low. Each word reads back as written.
- R3: Address 4 bit n enables rising-edge detection on line n. A pin change applied before a clock edge is seen as an edge by the pending and event logic two edges later, after two synchroniser stages.
- R4: Address 5 bit n enables falling-edge detection on line n. With both bits set, both directions of change are detected.
- R5: An enabled edge on line n sets a pending flag only if address 6 (interrupt mask) bit n is 1. Rising edges set bit n of address 8 and falling edges set bit n of address 9, each flag independent of the other.
- R6: Writing 1 to a bit of address 8 or 9 clears that pending flag, and writing 0 leaves it unchanged. A set arriving on the same clock as a clear wins, so the flag stays 1.
- R7: `irq[n]` is high exactly while (rising pending n OR falling pending n) AND interrupt mask n. Clearing the mask lowers `irq[n]` but keeps the pending flags readable.
- R8: An enabled edge on line n with address 7 (event mask) bit n set gives one single-cycle pulse on `evt[n]`. The event path sets no pending flag of its own.
- R9: Addresses 10 to 15 read 0, and writes to them change no register.
- R10: A change on a line whose trigger enable for that direction is 0 sets no flag and gives no pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_pins | input | NUM_PORTS*LINES | Raw pin levels; port p pin n at bit p*LINES+n |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address for reads and writes |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` (combinational) |
| irq | output | LINES | Per-line interrupt request level |
| evt | output | LINES | Per-line single-cycle event pulse |

## Verification
The assertions check four things on every cycle:
- A write-one clear empties a flag unless an edge sets it in the same cycle.
- An edge qualified for capture always lands in its pending register.
- Event pulses appear only on lines whose event mask was set on the cycle before.
- No interrupt is raised while both pending registers are empty, and writes to unused addresses leave all configuration stable.

Port routing through the selection fields, the exact synchroniser latency, the set-over-clear race, edges caused by re-pointing a line to another port, and the single-pulse width are shown only by the bench's scenarios. The bench compares pin changes and configuration against its own edge model.

// File: rtl/extint_pkg.sv
package extint_pkg;
  // Offsets of the control words, counted after the block of selection words.
  localparam int OFS_RTRIG = 0;
  localparam int OFS_FTRIG = 1;
  localparam int OFS_IMASK = 2;
  localparam int OFS_EMASK = 3;
  localparam int OFS_RPEND = 4;
  localparam int OFS_FPEND = 5;
  localparam int NUM_CTRL  = 6;

  // Width of the synchroniser chain in front of edge detection.
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/extint_cfg.sv
module extint_cfg
  import extint_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int SEL_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  output logic [LINES*SEL_W-1:0]   sel_flat,
  output logic [LINES-1:0]         rtrig,
  output logic [LINES-1:0]         ftrig,
  output logic [LINES-1:0]         imask,
  output logic [LINES-1:0]         emask,
  output logic [LINES-1:0]         clr_r,
  output logic [LINES-1:0]         clr_f
);
  localparam int SEL_REGS = (LINES * SEL_W) / DATA_W;
  localparam int CTRL_LO  = SEL_REGS;
  localparam int CTRL_HI  = SEL_REGS + NUM_CTRL;

  int a;
  always_comb a = int'(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_flat <= '0;
      rtrig    <= '0;
      ftrig    <= '0;
      imask    <= '0;
      emask    <= '0;
    end else if (we) begin
      if (a < SEL_REGS) begin
        sel_flat[a*DATA_W +: DATA_W] <= wdata;
      end else begin
        case (a - CTRL_LO)
          OFS_RTRIG: rtrig <= wdata[LINES-1:0];
          OFS_FTRIG: ftrig <= wdata[LINES-1:0];
          OFS_IMASK: imask <= wdata[LINES-1:0];
          OFS_EMASK: emask <= wdata[LINES-1:0];
          default:   ;
        endcase
      end
    end
  end

  // Write-one-to-clear strobes for the pending registers.
  always_comb begin
    clr_r = '0;
    clr_f = '0;
    if (we && a == CTRL_LO + OFS_RPEND) clr_r = wdata[LINES-1:0];
    if (we && a == CTRL_LO + OFS_FPEND) clr_f = wdata[LINES-1:0];
  end

  // R9: a write outside the decoded space leaves every configuration word alone.
  p_unused_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && a >= CTRL_HI) |=> ($stable(sel_flat) && $stable(rtrig) && $stable(ftrig)
                              && $stable(imask) && $stable(emask)));
endmodule

// File: rtl/extint_line_front.sv
module extint_line_front
  import extint_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int LINES     = 16,
  parameter int SEL_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS*LINES-1:0] port_pins,
  input  logic [LINES*SEL_W-1:0]     sel_flat,
  output logic [LINES-1:0]           rise,
  output logic [LINES-1:0]           fall
);
  logic [LINES-1:0] routed;
  logic [LINES-1:0] sync_q [SYNC_STAGES];
  logic [LINES-1:0] prev_q;

  // Per-line port multiplexer; an out-of-range selection gives a low line.
  for (genvar n = 0; n < LINES; n++) begin : g_mux
    logic [SEL_W-1:0] sel;
    assign sel = sel_flat[n*SEL_W +: SEL_W];
    always_comb begin
      routed[n] = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (int'(sel) == p) routed[n] = port_pins[p*LINES + n];
      end
    end
  end

  // Synchroniser chain, then one more sample for edge comparison.
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= routed;
      else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall = ~sync_q[SYNC_STAGES-1] & prev_q;
endmodule

// File: rtl/extint_pend.sv
module extint_pend #(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] rise,
  input  logic [LINES-1:0] fall,
  input  logic [LINES-1:0] rtrig,
  input  logic [LINES-1:0] ftrig,
  input  logic [LINES-1:0] imask,
  input  logic [LINES-1:0] emask,
  input  logic [LINES-1:0] clr_r,
  input  logic [LINES-1:0] clr_f,
  output logic [LINES-1:0] rpend,
  output logic [LINES-1:0] fpend,
  output logic [LINES-1:0] irq,
  output logic [LINES-1:0] evt
);
  logic [LINES-1:0] hit_r, hit_f, set_r, set_f;

  assign hit_r = rise & rtrig;
  assign hit_f = fall & ftrig;
  assign set_r = hit_r & imask;
  assign set_f = hit_f & imask;

  // A new edge overrides a clear written on the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpend <= '0;
      fpend <= '0;
      evt   <= '0;
    end else begin
      rpend <= (rpend & ~clr_r) | set_r;
      fpend <= (fpend & ~clr_f) | set_f;
      evt   <= (hit_r | hit_f) & emask;
    end
  end

  assign irq = (rpend | fpend) & imask;

  // R6: a cleared bit with no coincident set is empty on the next cycle.
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_r & ~set_r) != '0) |=> ((rpend & $past(clr_r & ~set_r)) == '0));

  // R5: a qualified rising edge is always captured.
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_r != '0) |=> ((rpend & $past(set_r)) == $past(set_r)));

  // R8: pulses only on lines whose event mask was set.
  p_evt_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt & ~$past(emask)) == '0));
endmodule

// File: rtl/extint_edge_ctrl.sv
module extint_edge_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int LINES     = 16,
  parameter int SEL_W     = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS*LINES-1:0] port_pins,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic [DATA_W-1:0]          reg_rdata,
  output logic [LINES-1:0]           irq,
  output logic [LINES-1:0]           evt
);
  localparam int SEL_REGS = (LINES * SEL_W) / DATA_W;

  logic [LINES*SEL_W-1:0] sel_flat;
  logic [LINES-1:0] rtrig, ftrig, imask, emask, clr_r, clr_f;
  logic [LINES-1:0] rise, fall, rpend, fpend;

  extint_cfg #(
    .LINES(LINES), .SEL_W(SEL_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .sel_flat(sel_flat), .rtrig(rtrig), .ftrig(ftrig), .imask(imask),
    .emask(emask), .clr_r(clr_r), .clr_f(clr_f)
  );

  extint_line_front #(
    .NUM_PORTS(NUM_PORTS), .LINES(LINES), .SEL_W(SEL_W)
  ) u_front (
    .clk(clk), .rst_n(rst_n), .port_pins(port_pins), .sel_flat(sel_flat),
    .rise(rise), .fall(fall)
  );

  extint_pend #(.LINES(LINES)) u_pend (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .rtrig(rtrig),
    .ftrig(ftrig), .imask(imask), .emask(emask), .clr_r(clr_r), .clr_f(clr_f),
    .rpend(rpend), .fpend(fpend), .irq(irq), .evt(evt)
  );

  int ra;
  always_comb ra = int'(reg_addr);

  always_comb begin
    reg_rdata = '0;
    if (ra < SEL_REGS) begin
      reg_rdata = sel_flat[ra*DATA_W +: DATA_W];
    end else begin
      case (ra - SEL_REGS)
        OFS_RTRIG: reg_rdata[LINES-1:0] = rtrig;
        OFS_FTRIG: reg_rdata[LINES-1:0] = ftrig;
        OFS_IMASK: reg_rdata[LINES-1:0] = imask;
        OFS_EMASK: reg_rdata[LINES-1:0] = emask;
        OFS_RPEND: reg_rdata[LINES-1:0] = rpend;
        OFS_FPEND: reg_rdata[LINES-1:0] = fpend;
        default:   reg_rdata = '0;
      endcase
    end
  end

  // R7: with both pending registers empty no request may be raised.
  p_irq_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rpend | fpend) == '0) |-> (irq == '0));
endmodule

// File: tb/extint_edge_ctrl_bench.sv
`timescale 1ns/1ps
module extint_edge_ctrl_bench;
  localparam int NP = 4;
  localparam int NL = 16;
  localparam logic [3:0] A_RT = 4'd4, A_FT = 4'd5, A_IM = 4'd6, A_EM = 4'd7,
                         A_RP = 4'd8, A_FP = 4'd9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP*NL-1:0] pins = '0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NL-1:0] irq, evt;

  // Bench-side view of the configuration and flags.
  logic [127:0] m_sel = '0;
  logic [NL-1:0] m_rt = '0, m_ft = '0, m_im = '0, m_em = '0, m_rp = '0, m_fp = '0;

  int n_vec = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  extint_edge_ctrl u_extint_edge_ctrl (
    .clk(clk), .rst_n(rst_n), .port_pins(pins), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq), .evt(evt)
  );

  function automatic logic [NL-1:0] line_vec(input logic [NP*NL-1:0] p, input logic [127:0] s);
    logic [NL-1:0] v;
    v = '0;
    for (int n = 0; n < NL; n++) begin
      if (int'(s[n*8 +: 8]) < NP) v[n] = p[int'(s[n*8 +: 8])*NL + n];
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic watch(output logic [NL-1:0] or_v, output int cnt);
    or_v = '0; cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      or_v |= evt;
      cnt += $countones(evt);
    end
  endtask

  task automatic settle_check(input logic [NL-1:0] l0, input string tag);
    logic [NL-1:0] l1, rise, fall, exp_evt, or_v;
    logic [31:0] d;
    int cnt;
    l1 = line_vec(pins, m_sel);
    rise = ~l0 & l1;
    fall = l0 & ~l1;
    exp_evt = ((rise & m_rt) | (fall & m_ft)) & m_em;
    m_rp |= rise & m_rt & m_im;
    m_fp |= fall & m_ft & m_im;
    watch(or_v, cnt);
    chk({tag, " R8 event lines"}, 32'(or_v), 32'(exp_evt));
    chk({tag, " R8 single pulse"}, 32'(cnt), 32'($countones(exp_evt)));
    rd(A_RP, d); chk({tag, " R5 rising pending"}, d, 32'(m_rp));
    rd(A_FP, d); chk({tag, " R5 falling pending"}, d, 32'(m_fp));
    chk({tag, " R7 irq"}, 32'(irq), 32'((m_rp | m_fp) & m_im));
  endtask

  task automatic do_pins(input logic [NP*NL-1:0] np, input string tag);
    logic [NL-1:0] l0;
    l0 = line_vec(pins, m_sel);
    @(negedge clk);
    pins = np;
    settle_check(l0, tag);
  endtask

  task automatic do_cfg(input logic [3:0] a, input logic [31:0] d, input string tag);
    logic [NL-1:0] l0;
    logic [31:0] exp, r;
    l0 = line_vec(pins, m_sel);
    exp = '0;
    case (a)
      4'd0, 4'd1, 4'd2, 4'd3: begin m_sel[int'(a)*32 +: 32] = d; exp = d; end
      A_RT: begin m_rt = d[NL-1:0]; exp = 32'(m_rt); end
      A_FT: begin m_ft = d[NL-1:0]; exp = 32'(m_ft); end
      A_IM: begin m_im = d[NL-1:0]; exp = 32'(m_im); end
      A_EM: begin m_em = d[NL-1:0]; exp = 32'(m_em); end
      default: exp = '0;
    endcase
    wr(a, d);
    settle_check(l0, tag);
    rd(a, r);
    chk({tag, " R2/R9 readback"}, r, exp);
  endtask

  task automatic do_clear(input logic [3:0] a, input logic [NL-1:0] d, input string tag);
    logic [NL-1:0] l0;
    l0 = line_vec(pins, m_sel);
    if (a == A_RP) m_rp &= ~d; else m_fp &= ~d;
    wr(a, 32'(d));
    settle_check(l0, tag);
  endtask

  function automatic logic [31:0] rnd_sel_word();
    logic [31:0] w;
    for (int k = 0; k < 4; k++) begin
      w[k*8 +: 8] = ($urandom_range(0, 9) == 0) ? 8'hFF : 8'($urandom_range(0, 5));
    end
    return w;
  endfunction

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every register and both outputs.
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      chk("R1 reset register", d, 32'h0);
    end
    chk("R1 reset irq", 32'(irq), 32'h0);
    chk("R1 reset evt", 32'(evt), 32'h0);

    // R3: rising edge on line 0 (port 0).
    do_cfg(A_IM, 32'hFFFF, "R5 mask");
    do_cfg(A_RT, 32'h0001, "R3 setup");
    do_pins(pins | 64'h1, "R3 rise line0");
    do_pins(pins & ~64'h1, "R10 fall without enable");
    // R4: both directions enabled.
    do_cfg(A_FT, 32'h0001, "R4 setup");
    do_pins(pins | 64'h1, "R4 rise");
    do_pins(pins & ~64'h1, "R4 fall");
    // R6: write zero ignored, write one clears.
    do_clear(A_RP, 16'h0000, "R6 zero write");
    do_clear(A_RP, 16'h0001, "R6 clear rising");
    do_clear(A_FP, 16'h0001, "R6 clear falling");
    // R2: line 1 taken from port 2; port 0 bit 1 is then ignored.
    do_cfg(4'd0, 32'h0000_0200, "R2 select port2");
    do_cfg(A_RT, 32'h0002, "R2 trig");
    do_pins(pins | (64'h1 << (2*NL + 1)), "R2 port2 rise");
    do_pins(pins | (64'h1 << 1), "R2 other port ignored");
    do_cfg(A_FT, 32'h0002, "R2 trig fall");
    do_cfg(4'd0, 32'h0000_0700, "R2 out of range select");
    // R8: event only on line 2, no pending.
    do_cfg(A_IM, 32'hFFFB, "R8 mask");
    do_cfg(A_EM, 32'h0004, "R8 emask");
    do_cfg(A_RT, 32'h0004, "R8 trig");
    do_pins(pins | (64'h1 << 2), "R8 event pulse");
    // R10: no triggers, nothing happens.
    do_cfg(A_RT, 32'h0, "R10 off");
    do_cfg(A_FT, 32'h0, "R10 off");
    do_pins(pins ^ 64'hFFFF_FFFF_FFFF_FFFF, "R10 toggle all");
    // R7: masking hides irq but keeps flags.
    do_cfg(A_RT, 32'hFFFF, "R7 trig");
    do_pins(pins ^ 64'h0000_0000_0000_00F0, "R7 set flags");
    do_cfg(A_IM, 32'h0000, "R7 mask off");
    do_cfg(A_IM, 32'hFFFF, "R7 mask on");
    do_clear(A_RP, 16'hFFFF, "R7 flush");
    do_clear(A_FP, 16'hFFFF, "R7 flush");

    // R6: set and clear on the same cycle, set wins.
    do_cfg(4'd0, 32'h0, "R6 select");
    do_cfg(A_EM, 32'h0, "R6 emask");
    do_cfg(A_FT, 32'h0, "R6 ftrig");
    do_cfg(A_RT, 32'h0008, "R6 rtrig");
    do_cfg(A_IM, 32'h0008, "R6 imask");
    do_pins(pins & ~64'h8, "R6 low");
    do_pins(pins | 64'h8, "R6 first rise");
    do_pins(pins & ~64'h8, "R6 back low");
    @(negedge clk); pins[3] = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = A_RP; wdata = 32'h8;
    @(negedge clk); we = 1'b0;
    repeat (4) @(negedge clk);
    rd(A_RP, d);
    chk("R6 set beats clear", 32'(d[3]), 32'h1);

    // R9: unused addresses.
    do_cfg(4'd12, 32'hFFFF_FFFF, "R9 unused write");
    rd(A_RT, d); chk("R9 rtrig untouched", d, 32'(m_rt));
    rd(4'd0, d); chk("R9 select untouched", d, m_sel[31:0]);

    // Constrained random mix.
    for (int a = 0; a < 4; a++) do_cfg(4'(a), rnd_sel_word(), "rand select");
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 50) begin
        logic [NP*NL-1:0] flip;
        flip = {$urandom(), $urandom()} & {$urandom(), $urandom()};
        do_pins(pins ^ flip, "rand pins R3/R4");
      end else if (r < 62) begin
        do_cfg(4'($urandom_range(0, 3)), rnd_sel_word(), "rand select R2");
      end else if (r < 80) begin
        do_cfg(4'($urandom_range(4, 7)), $urandom(), "rand ctrl");
      end else if (r < 95) begin
        do_clear(($urandom_range(0, 1) == 0) ? A_RP : A_FP, 16'($urandom()), "rand clear R6");
      end else begin
        do_cfg(4'($urandom_range(10, 15)), $urandom(), "rand unused R9");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule